// File: doc/BRIEF.md
# Text Cursor Generator with Field-Rate Blink

This block decides, character cell by character cell, whether the text cursor is drawn. It compares the refresh address of the current cell with a programmed 14-bit cursor position. It also checks that the current raster line lies inside a programmed band of scan lines. The result is qualified by the display-enable signal and by a blink phase. The blink phase comes from a small field counter that steps on each rising edge of a vertical-sync input.

A 2-bit mode field sits in the upper bits of the cursor-start value. It picks one of four behaviours: a steady cursor, a cursor that is never drawn, a slow blink or a slower blink. Both blink rates run at a 50% duty cycle. The cursor output is registered, so it lines up with the next character clock after its inputs. A video pipeline can treat it as one stage.

Top module: `cursor_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `cursor_out` is 0. Reset clears the field counter, so a cursor in either blink mode is in its shown phase straight after reset.
- R2: The cursor position is `{cpos_hi[5:0], cpos_lo[7:0]}`, with `cpos_hi` as address bits 13:8. The cursor is shown only when all 14 bits of `refresh_addr` equal this position.
- R3: The cursor is shown only when `first_line <= raster_line <= last_line`. Here `first_line` is `cstart[4:0]` and `last_line` is `cend[4:0]`, and both bounds are inclusive.
- R4: When `cstart[4:0]` is greater than `cend`, no raster line shows the cursor.
- R5: When `disp_en` is 0, `cursor_out` is 0.
- R6: Mode `cstart[6:5]` = 00 gives a steady cursor, independent of the field counter.
- R7: Mode `cstart[6:5]` = 01 never shows the cursor.
- R8: Mode `cstart[6:5]` = 10 shows the cursor while bit 3 of the field counter is 0. This gives 8 fields shown and then 8 fields hidden.
- R9: Mode `cstart[6:5]` = 11 shows the cursor while bit 4 of the field counter is 0. This gives 16 fields shown and then 16 fields hidden.
- R10: The field counter advances exactly once for each 0-to-1 transition of `vsync`. Holding `vsync` high for several cycles counts once.
- R11: `cursor_out` reflects the inputs sampled at the previous rising clock edge, a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_addr | input | 14 | Refresh address of the current cell |
| raster_line | input | 5 | Scan line within the current character row |
| disp_en | input | 1 | High while the cell is in the displayed area |
| vsync | input | 1 | Vertical sync pulse; its rising edge marks a new field |
| cstart | input | 7 | Cursor mode in bits 6:5, first scan line in bits 4:0 |
| cend | input | 5 | Last scan line of the cursor |
| cpos_hi | input | 6 | Cursor position bits 13:8 |
| cpos_lo | input | 8 | Cursor position bits 7:0 |
| cursor_out | output | 1 | Registered active-high cursor signal |

## Verification
The bench builds the block with its default blink taps, bit 3 for the faster rate and bit 4 for the slower one, on a 5-bit field counter. With these taps, both blink transitions and the counter's wrap-free region are reached within about two dozen vsync pulses. That makes it cheap to step to field counts 7, 8, 15 and 16, where the two blink modes change phase. A long held vsync is placed just before a phase boundary. This way, any extra count caused by the held level moves the observed phase and is caught at the output.

// File: rtl/cur_pkg.sv
package cur_pkg;

    localparam int CUR_ADDR_W = 14;
    localparam int CUR_HI_W   = 6;
    localparam int CUR_LO_W   = 8;
    localparam int CUR_LINE_W = 5;
    localparam int CUR_MODE_W = 2;
    localparam int CUR_CSTART_W = CUR_LINE_W + CUR_MODE_W;

    typedef enum logic [CUR_MODE_W-1:0] {
        CM_STEADY = 2'b00,
        CM_HIDDEN = 2'b01,
        CM_BLINK_FAST = 2'b10,
        CM_BLINK_SLOW = 2'b11
    } cur_mode_e;

    typedef struct packed {
        cur_mode_e               mode;
        logic [CUR_LINE_W-1:0]   first_line;
        logic [CUR_LINE_W-1:0]   last_line;
        logic [CUR_ADDR_W-1:0]   pos;
    } cur_cfg_t;

    function automatic cur_cfg_t unpack_cfg(
        input logic [CUR_CSTART_W-1:0] cstart,
        input logic [CUR_LINE_W-1:0]   cend,
        input logic [CUR_HI_W-1:0]     hi,
        input logic [CUR_LO_W-1:0]     lo
    );
        cur_cfg_t c;
        c.mode       = cur_mode_e'(cstart[CUR_CSTART_W-1:CUR_LINE_W]);
        c.first_line = cstart[CUR_LINE_W-1:0];
        c.last_line  = cend;
        c.pos        = {hi, lo};
        return c;
    endfunction

    function automatic logic line_in_band(
        input logic [CUR_LINE_W-1:0] line,
        input logic [CUR_LINE_W-1:0] lo_b,
        input logic [CUR_LINE_W-1:0] hi_b
    );
        return (line >= lo_b) && (line <= hi_b);
    endfunction

endpackage

// File: rtl/cur_field_ctr.sv
module cur_field_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync,
    output logic [CNT_W-1:0] field_cnt
);
    logic vsync_q;
    logic vs_rise;

    assign vs_rise = vsync & ~vsync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vsync_q   <= 1'b0;
            field_cnt <= '0;
        end else begin
            vsync_q <= vsync;
            if (vs_rise)
                field_cnt <= field_cnt + 1'b1;
        end
    end

    // R10: one step per rising edge of vsync
    p_step_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
        (vsync && !vsync_q) |=> (field_cnt == $past(field_cnt) + 1'b1));
    // R10: no step without a rising edge
    p_hold_otherwise_r10: assert property (@(posedge clk) disable iff (rst)
        !(vsync && !vsync_q) |=> $stable(field_cnt));

endmodule

// File: rtl/cur_blink_sel.sv
module cur_blink_sel
    import cur_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int FAST_BIT = 3,
    parameter int SLOW_BIT = 4
) (
    input  cur_mode_e        mode,
    input  logic [CNT_W-1:0] field_cnt,
    output logic             phase_on
);
    logic fast_on;
    logic slow_on;

    generate
        if (FAST_BIT < CNT_W) begin : g_fast
            assign fast_on = ~field_cnt[FAST_BIT];
        end else begin : g_fast_none
            assign fast_on = 1'b1;
        end
        if (SLOW_BIT < CNT_W) begin : g_slow
            assign slow_on = ~field_cnt[SLOW_BIT];
        end else begin : g_slow_none
            assign slow_on = 1'b1;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            CM_STEADY:     phase_on = 1'b1;
            CM_HIDDEN:     phase_on = 1'b0;
            CM_BLINK_FAST: phase_on = fast_on;
            CM_BLINK_SLOW: phase_on = slow_on;
            default:       phase_on = 1'b0;
        endcase
    end

    // R7: the suppressed mode never opens the phase
    always_comb begin
        if (mode == CM_HIDDEN)
            p_hidden_closed_r7: assert (!phase_on);
    end

endmodule

// File: rtl/cur_match.sv
module cur_match
    import cur_pkg::*;
(
    input  cur_cfg_t                cfg,
    input  logic [CUR_ADDR_W-1:0]   refresh_addr,
    input  logic [CUR_LINE_W-1:0]   raster_line,
    output logic                    addr_hit,
    output logic                    line_hit
);
    assign addr_hit = (refresh_addr == cfg.pos);
    assign line_hit = line_in_band(raster_line, cfg.first_line, cfg.last_line);

    // R4: an inverted band covers no line
    always_comb begin
        if (cfg.first_line > cfg.last_line)
            p_empty_band_r4: assert (!line_hit);
    end

endmodule

// File: rtl/cursor_gen.sv
module cursor_gen
    import cur_pkg::*;
#(
    parameter int FAST_BIT = 3,
    parameter int SLOW_BIT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CUR_ADDR_W-1:0]   refresh_addr,
    input  logic [CUR_LINE_W-1:0]   raster_line,
    input  logic                    disp_en,
    input  logic                    vsync,
    input  logic [CUR_CSTART_W-1:0] cstart,
    input  logic [CUR_LINE_W-1:0]   cend,
    input  logic [CUR_HI_W-1:0]     cpos_hi,
    input  logic [CUR_LO_W-1:0]     cpos_lo,
    output logic                    cursor_out
);
    localparam int CNT_W = ((SLOW_BIT > FAST_BIT) ? SLOW_BIT : FAST_BIT) + 1;

    cur_cfg_t          cfg;
    logic [CNT_W-1:0]  field_cnt;
    logic              addr_hit;
    logic              line_hit;
    logic              phase_on;

    assign cfg = unpack_cfg(cstart, cend, cpos_hi, cpos_lo);

    cur_field_ctr #(.CNT_W(CNT_W)) u_fields (
        .clk       (clk),
        .rst       (rst),
        .vsync     (vsync),
        .field_cnt (field_cnt)
    );

    cur_blink_sel #(
        .CNT_W    (CNT_W),
        .FAST_BIT (FAST_BIT),
        .SLOW_BIT (SLOW_BIT)
    ) u_blink (
        .mode      (cfg.mode),
        .field_cnt (field_cnt),
        .phase_on  (phase_on)
    );

    cur_match u_match (
        .cfg          (cfg),
        .refresh_addr (refresh_addr),
        .raster_line  (raster_line),
        .addr_hit     (addr_hit),
        .line_hit     (line_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cursor_out <= 1'b0;
        else
            cursor_out <= disp_en & addr_hit & line_hit & phase_on;
    end

    // R5: blanked cells never carry the cursor on the next clock
    p_blank_off_r5: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> !cursor_out);
    // R2: a mismatched address yields no cursor
    p_addr_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (refresh_addr != {cpos_hi, cpos_lo}) |=> !cursor_out);
    // R7: suppressed mode keeps the output low
    p_hidden_off_r7: assert property (@(posedge clk) disable iff (rst)
        (cstart[6:5] == 2'b01) |=> !cursor_out);
    // R4: inverted band keeps the output low
    p_band_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (cstart[4:0] > cend) |=> !cursor_out);
    // R1: output clear after a reset cycle
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !cursor_out);

endmodule

// File: tb/tb_cursor_gen.sv
module tb_cursor_gen;

    typedef struct packed {
        logic [13:0] addr;
        logic [4:0]  line;
        logic        de;
        logic [6:0]  cs;
        logic [4:0]  ce;
        logic [5:0]  hi;
        logic [7:0]  lo;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    // field counter stays 0 while the table runs
    localparam vec_t VECS [NV] = '{
        '{14'h1234, 5'd4, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b1, 4'd2},  // R2 hit, R6 steady
        '{14'h1235, 5'd4, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b0, 4'd2},  // R2 low bit off
        '{14'h0234, 5'd4, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b0, 4'd2},  // R2 high bit off
        '{14'h3FFF, 5'd4, 1'b1, 7'h03, 5'd6, 6'h3F, 8'hFF, 1'b1, 4'd2},  // R2 top address
        '{14'h1234, 5'd3, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b1, 4'd3},  // R3 first line
        '{14'h1234, 5'd6, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b1, 4'd3},  // R3 last line
        '{14'h1234, 5'd7, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b0, 4'd3},  // R3 below band
        '{14'h1234, 5'd2, 1'b1, 7'h03, 5'd6, 6'h12, 8'h34, 1'b0, 4'd3},  // R3 above band
        '{14'h1234, 5'd5, 1'b1, 7'h05, 5'd5, 6'h12, 8'h34, 1'b1, 4'd3},  // R3 single line
        '{14'h1234, 5'd5, 1'b1, 7'h07, 5'd3, 6'h12, 8'h34, 1'b0, 4'd4},  // R4 inverted
        '{14'h1234, 5'd7, 1'b1, 7'h07, 5'd3, 6'h12, 8'h34, 1'b0, 4'd4},  // R4 inverted, at start
        '{14'h1234, 5'd4, 1'b0, 7'h03, 5'd6, 6'h12, 8'h34, 1'b0, 4'd5},  // R5 blanked
        '{14'h1234, 5'd4, 1'b1, 7'h23, 5'd6, 6'h12, 8'h34, 1'b0, 4'd7},  // R7 hidden
        '{14'h1234, 5'd4, 1'b1, 7'h43, 5'd6, 6'h12, 8'h34, 1'b1, 4'd8},  // R8 phase on at 0
        '{14'h1234, 5'd4, 1'b1, 7'h63, 5'd6, 6'h12, 8'h34, 1'b1, 4'd9}   // R9 phase on at 0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] refresh_addr = '0;
    logic [4:0]  raster_line = '0;
    logic        disp_en = 1'b0;
    logic        vsync = 1'b0;
    logic [6:0]  cstart = '0;
    logic [4:0]  cend = '0;
    logic [5:0]  cpos_hi = '0;
    logic [7:0]  cpos_lo = '0;
    logic        cursor_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cursor_gen dut (
        .clk          (clk),
        .rst          (rst),
        .refresh_addr (refresh_addr),
        .raster_line  (raster_line),
        .disp_en      (disp_en),
        .vsync        (vsync),
        .cstart       (cstart),
        .cend         (cend),
        .cpos_hi      (cpos_hi),
        .cpos_lo      (cpos_lo),
        .cursor_out   (cursor_out)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (cursor_out !== exp) begin
            errors++;
            $display("FAIL %s: cursor_out=%b expected %b", req, cursor_out, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        refresh_addr = v.addr;
        raster_line  = v.line;
        disp_en      = v.de;
        cstart       = v.cs;
        cend         = v.ce;
        cpos_hi      = v.hi;
        cpos_lo      = v.lo;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cstart[6:5] = m;
        @(negedge clk);
    endtask

    task automatic pulse_vs(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) vsync = 1'b1;
            @(negedge clk) vsync = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: matching inputs held under reset
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b1);

        // table walk
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k]);
            @(negedge clk);
            check($sformatf("R%0d", VECS[k].req), VECS[k].exp);
        end

        // R11: change lands only after the next edge
        @(negedge clk) drive(VECS[0]);
        @(negedge clk);
        disp_en = 1'b0;
        #1 check("R11", 1'b1);
        @(negedge clk);
        check("R11", 1'b0);
        disp_en = 1'b1;

        // blink sequencing; steady must ignore the counter (R6)
        pulse_vs(7);                       // count 7
        set_mode(2'b10); check("R8", 1'b1);
        // R10: long high level counts once -> 8
        @(negedge clk) vsync = 1'b1;
        repeat (6) @(negedge clk);
        vsync = 1'b0;
        set_mode(2'b10); check("R8", 1'b0);
        set_mode(2'b11); check("R9", 1'b1);
        set_mode(2'b00); check("R6", 1'b1);
        pulse_vs(7);                       // count 15
        set_mode(2'b10); check("R10", 1'b0);
        pulse_vs(1);                       // count 16
        set_mode(2'b10); check("R8", 1'b1);
        set_mode(2'b11); check("R9", 1'b0);
        set_mode(2'b00); check("R6", 1'b1);
        pulse_vs(8);                       // count 24
        set_mode(2'b10); check("R8", 1'b0);
        set_mode(2'b11); check("R9", 1'b0);

        // R1: reset clears the field counter
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);
        rst = 1'b0;
        set_mode(2'b10); check("R1", 1'b1);
        set_mode(2'b11); check("R1", 1'b1);

        done = 1'b1;
        finish_run();
    end

endmodule